// File: doc/BRIEF.md
# Watchdog Kick Extender

This block lets logic that checks in only rarely keep a short-timeout watchdog from firing. A free-running periodic tick, arriving well inside the watchdog's own timeout, is counted in a saturating counter. While that count is below a threshold, every tick sends one kick pulse to the watchdog and advances the count by one. When the count reaches the threshold, kicks stop and the watchdog expires on its own schedule.

The application services the block through a single alive strobe, which returns the count to zero. The longest gap the application may leave between strobes is therefore the threshold multiplied by the tick period. For example, a tick near 15 Hz and a threshold of 3600 allow about four minutes. If the tick source itself dies, kicks cease as well, so the watchdog still catches a stalled timebase within its short timeout. For kicks to arrive in time, the tick must run at no less than twice the watchdog's timeout rate. The watchdog is outside this block.

Top module: `wdk_extender`

## Requirements
- R1: After reset, the kick output is low and the internal count is zero.
- R2: A tick with alive low and count below `thresh` raises `kick` for exactly the next cycle and adds one to the count.
- R3: A tick with alive low and count at or above `thresh` gives no kick and leaves the count unchanged.
- R4: An alive strobe clears the count to zero, so that kicks resume on later ticks.
- R5: When alive and tick are high in the same cycle, the clear wins: no kick follows, and the count becomes zero.
- R6: With `thresh` equal to 0, no tick ever produces a kick.
- R7: `thresh` is sampled on every tick. If it is lowered to or below the count, kicks stop without the count changing. If it is raised again, kicking continues from the stored count.
- R8: In cycles with no tick and no alive strobe, no kick is issued and the count holds.
- R9: Ticks on consecutive cycles give kicks on consecutive cycles, each lasting one cycle.
- R10: With `thresh` at its largest value (65535 for 16 bits), exactly that many kicks are issued before saturation, and the count never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle periodic timebase pulse |
| alive | input | 1 | Application check-in strobe, clears the count |
| thresh | input | CNT_W (16) | Number of kicks allowed between check-ins |
| kick | output | 1 | One-cycle kick pulse towards the watchdog |

## Verification
Ticks spaced several cycles apart, with a small threshold, show whether kicking stops exactly at the threshold. They also show whether an alive strobe restarts it from zero. Back-to-back ticks separate a true one-cycle kick pulse from a stretched or merged one. A threshold lowered and then raised in the middle of a run shows whether the count holds while kicks are suppressed, rather than being cleared or still advancing. Alive and tick in the same cycle, a zero threshold, and a full 65535-tick run probe clear priority, the empty window and wrap-around at the top of the counter.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    // Per-cycle decision taken from tick, alive strobe and threshold compare
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,   // no tick, no strobe
        ACT_CLEAR = 2'd1,   // alive strobe, wins over tick
        ACT_STEP  = 2'd2,   // tick below threshold: count up and kick
        ACT_STALL = 2'd3    // tick at/above threshold: nothing
    } wdk_act_e;

endpackage

// File: rtl/wdk_decide.sv
module wdk_decide #(
    parameter int CNT_W = 16
) (
    input  logic                 tick,
    input  logic                 alive,
    input  logic [CNT_W-1:0]     count,
    input  logic [CNT_W-1:0]     thresh,
    output wdk_pkg::wdk_act_e    act
);
    import wdk_pkg::*;

    logic below;

    always_comb begin
        below = (count < thresh);
        if (alive)
            act = ACT_CLEAR;
        else if (tick && below)
            act = ACT_STEP;
        else if (tick)
            act = ACT_STALL;
        else
            act = ACT_HOLD;
    end

endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  wdk_pkg::wdk_act_e    act,
    output logic [CNT_W-1:0]     count
);
    import wdk_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (act)
            ACT_CLEAR: st_d.cnt = '0;
            ACT_STEP:  st_d.cnt = st_q.cnt + 1'b1;
            default:   st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse (
    input  logic                 clk,
    input  logic                 rst_n,
    input  wdk_pkg::wdk_act_e    act,
    output logic                 kick
);
    import wdk_pkg::*;

    typedef struct packed {
        logic kick;
    } pulse_state_t;

    pulse_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.kick = (act == ACT_STEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign kick = st_q.kick;

endmodule

// File: rtl/wdk_extender.sv
module wdk_extender #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             alive,
    input  logic [CNT_W-1:0] thresh,
    output logic             kick
);
    import wdk_pkg::*;

    wdk_act_e         act;
    logic [CNT_W-1:0] count_q;

    wdk_decide #(.CNT_W(CNT_W)) u_decide (
        .tick   (tick),
        .alive  (alive),
        .count  (count_q),
        .thresh (thresh),
        .act    (act)
    );

    wdk_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .count  (count_q)
    );

    wdk_pulse u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .kick   (kick)
    );

endmodule

// File: rtl/wdk_extender_chk.sv
module wdk_extender_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             alive,
    input logic [CNT_W-1:0] thresh,
    input logic             kick,
    input logic [CNT_W-1:0] count_q
);

    // R2
    step_kicks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !alive && count_q < thresh) |=> (kick && count_q == $past(count_q) + 1'b1));

    // R3
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !alive && count_q >= thresh) |=> (!kick && $stable(count_q)));

    // R5
    alive_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alive |=> (!kick && count_q == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !alive) |=> (!kick && $stable(count_q)));

    // R10
    kick_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> (count_q != '0));

endmodule

bind wdk_extender wdk_extender_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .alive   (alive),
    .thresh  (thresh),
    .kick    (kick),
    .count_q (count_q)
);

// File: tb/wdk_extender_test.sv
module wdk_extender_test;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             alive = 1'b0;
    logic [CNT_W-1:0] thresh = '0;
    logic             kick;

    int checks = 0;
    int errors = 0;
    int model_cnt = 0;
    int kick_tally = 0;

    typedef struct {
        logic  exp;
        string req;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    wdk_extender #(.CNT_W(CNT_W)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .alive  (alive),
        .thresh (thresh),
        .kick   (kick)
    );

    // Driver: one cycle of stimulus, expected kick pushed to the scoreboard
    task automatic step(input logic t, input logic a, input int thr, input string req);
        item_t it;
        @(negedge clk);
        tick   = t;
        alive  = a;
        thresh = thr[CNT_W-1:0];
        it.req = req;
        it.exp = 1'b0;
        if (a)
            model_cnt = 0;
        else if (t && model_cnt < thr) begin
            model_cnt = model_cnt + 1;
            it.exp = 1'b1;
        end
        sb.push_back(it);
    endtask

    task automatic idle(input int n, input int thr, input string req);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, thr, req);
    endtask

    // Monitor: compares the kick produced after each driven cycle
    always @(posedge clk) begin
        item_t it;
        #1;
        if (rst_n && sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (kick) kick_tally++;
            if (kick !== it.exp) begin
                errors++;
                $display("FAIL %s: kick=%0b expected %0b", it.req, kick, it.exp);
            end
        end
    end

    task automatic expect_tally(input int n, input string req);
        wait (sb.size() == 0);
        @(negedge clk);
        checks++;
        if (kick_tally != n) begin
            errors++;
            $display("FAIL %s: kicks=%0d expected %0d", req, kick_tally, n);
        end
        kick_tally = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (kick !== 1'b0) begin
            errors++;
            $display("FAIL R1: kick=%0b expected 0", kick);
        end
        rst_n = 1'b1;

        // R2 / R3: spaced ticks, threshold 5
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b0, 5, "R2_R3");
            idle(2, 5, "R8");
        end
        expect_tally(5, "R3");

        // R4: alive restarts kicking
        step(1'b0, 1'b1, 5, "R4");
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 5, "R4_R9");
        expect_tally(5, "R4");

        // R5: alive with tick in the same cycle
        step(1'b1, 1'b1, 5, "R5");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 5, "R5");
        expect_tally(5, "R5");

        // R6: zero threshold
        step(1'b0, 1'b1, 0, "R6");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 0, "R6");
        expect_tally(0, "R6");

        // R7: lower then raise threshold, count held meanwhile
        step(1'b0, 1'b1, 10, "R7");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 10, "R7");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 2, "R7");
        for (int i = 0; i < 9; i++) step(1'b1, 1'b0, 6, "R7");
        expect_tally(6, "R7");

        // R8: no ticks at all
        step(1'b0, 1'b1, 6, "R8");
        idle(20, 6, "R8");
        expect_tally(0, "R8");

        // R9: back-to-back ticks
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 6, "R9");
        idle(2, 6, "R9");
        expect_tally(4, "R9");

        // R10: full-range threshold
        step(1'b0, 1'b1, 65535, "R10");
        for (int i = 0; i < 65540; i++) step(1'b1, 1'b0, 65535, "R10");
        expect_tally(65535, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule